// File: doc/BRIEF.md
# Phased System Reset Sequencer

This block merges a set of active-low reset requests into one combined reset. From it the block builds three staged active-low resets: one for the clock generator, one for the peripherals and one for the processor core. When any request is active, all three outputs are held low. When the last request clears, the outputs are released one after another, in a fixed order and with fixed gaps between them. Blocks that come up earlier, such as a flash interface, therefore have their set-up time before the core starts to fetch.

The first release is timed on the free-running oscillator clock, because that clock keeps running while the chip is held in reset. Its length depends on a power-on flag: a power-on reset gets the long stretch and any other cause gets the short one. The clock-generation reset is passed through a synchronizer into the system-clock domain. The peripheral and core stages are then timed on the system clock. Each output rises on the falling edge of the clock that times it, so logic clocked on rising edges sees a clean half cycle before it.

There is no data path, so there is no valid/ready interface. Every pin is a plain level or clock.

Top module: `rst_phase_seq`

## Requirements
- R1: The combined reset is active whenever at least one bit of `rst_src_n` is 0. While it is active, `clkgen_rst_n`, `perip_rst_n` and `core_rst_n` are all 0.
- R2: When any source bit falls, all three outputs go to 0 without waiting for an edge of either clock.
- R3: If `por_flag` was 1 at the oscillator rising edges while the reset was active, `clkgen_rst_n` rises after the LONG_STRETCH-th (default 96) `osc_clk` rising edge that follows the release of the combined reset.
- R4: If `por_flag` was 0 at those edges, the stretch is SHORT_STRETCH (default 32) `osc_clk` rising edges.
- R5: `clkgen_rst_n` only rises on a falling edge of `osc_clk`.
- R6: `perip_rst_n` rises on the `sys_clk` falling edge that follows the (SYNC_STAGES + STAGE_LEN)-th (default 34) `sys_clk` rising edge after `clkgen_rst_n` rose. This count covers the two-stage synchronizer plus 32 counted cycles.
- R7: `core_rst_n` rises on the `sys_clk` falling edge that follows the STAGE_LEN-th (default 32) `sys_clk` rising edge after `perip_rst_n` rose.
- R8: The outputs are released strictly in order: `core_rst_n` is never 1 while `perip_rst_n` is 0, and `perip_rst_n` is never 1 while `clkgen_rst_n` is 0.
- R9: A source asserted part way through the sequence aborts it. After that source clears, the whole sequence runs again from the start, with the stretch length chosen by the new `por_flag` value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Free-running oscillator clock; times the stretch |
| sys_clk | input | 1 | System clock; times the peripheral and core stages |
| rst_src_n | input | NUM_SRC | Active-low reset requests (power-on, pin, watchdog, software, ...) |
| por_flag | input | 1 | 1 when the pending reset is a power-on reset; sampled while the reset is active |
| clkgen_rst_n | output | 1 | Active-low clock-generation reset |
| perip_rst_n | output | 1 | Active-low peripheral reset |
| core_rst_n | output | 1 | Active-low core reset |

## Verification
The sequence is started in turn from each single source and from several sources at once. Power-on and non-power-on causes alternate, which separates the long stretch from the short one and shows that every source bit reaches the combiner. The release counts are measured edge by edge against both clocks, so an off-by-one in the synchronizer or in either stage counter is caught. Asserting a source in the gap between the first and second release shows the difference between a sequencer that restarts and one that resumes.

// File: rtl/rst_seq_pkg.sv
`timescale 1ns/10ps
package rst_seq_pkg;

  localparam int unsigned DEF_NUM_SRC = 4;
  localparam int unsigned DEF_LONG    = 96;
  localparam int unsigned DEF_SHORT   = 32;
  localparam int unsigned DEF_STAGE   = 32;
  localparam int unsigned DEF_SYNC    = 2;

  // bits needed to hold the value max_val
  function automatic int unsigned cnt_w(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/rst_src_combine.sv
`timescale 1ns/10ps
module rst_src_combine #(
  parameter int unsigned NUM_SRC = rst_seq_pkg::DEF_NUM_SRC
) (
  input  logic               osc_clk,
  input  logic [NUM_SRC-1:0] src_n,
  input  logic               por_flag,
  output logic               comb_n,
  output logic               por_cause
);

  // any low request holds the combined reset low
  assign comb_n = &src_n;

  // cause is captured on the free-running clock while reset is held
  always_ff @(posedge osc_clk) begin
    if (!comb_n) por_cause <= por_flag;
  end

endmodule

// File: rtl/rst_osc_stretch.sv
`timescale 1ns/10ps
module rst_osc_stretch #(
  parameter int unsigned LONG_STRETCH  = rst_seq_pkg::DEF_LONG,
  parameter int unsigned SHORT_STRETCH = rst_seq_pkg::DEF_SHORT,
  parameter int unsigned SYNC_STAGES   = rst_seq_pkg::DEF_SYNC
) (
  input  logic osc_clk,
  input  logic comb_n,
  input  logic por_cause,
  output logic clkgen_rst_n
);
  import rst_seq_pkg::*;

  localparam int unsigned W = cnt_w(LONG_STRETCH);
  // synchronizer edges count toward the stretch
  localparam logic [W-1:0] LONG_TGT  = W'(LONG_STRETCH - SYNC_STAGES);
  localparam logic [W-1:0] SHORT_TGT = W'(SHORT_STRETCH - SYNC_STAGES);

  logic [SYNC_STAGES-1:0] arm_q;
  logic [W-1:0]           cnt_q;
  logic [W-1:0]           target;
  logic                   armed;
  logic                   done;
  logic                   rel_q;

  assign target = por_cause ? LONG_TGT : SHORT_TGT;
  assign armed  = arm_q[SYNC_STAGES-1];
  assign done   = (cnt_q == target);

  // release of the asynchronous combined reset, synchronized
  always_ff @(posedge osc_clk or negedge comb_n) begin
    if (!comb_n) arm_q <= '0;
    else         arm_q <= (arm_q << 1) | SYNC_STAGES'(1);
  end

  always_ff @(posedge osc_clk or negedge comb_n) begin
    if (!comb_n)                  cnt_q <= '0;
    else if (armed && !done)      cnt_q <= cnt_q + 1'b1;
  end

  // release on the falling edge
  always_ff @(negedge osc_clk or negedge comb_n) begin
    if (!comb_n) rel_q <= 1'b0;
    else         rel_q <= done;
  end

  assign clkgen_rst_n = rel_q;

endmodule

// File: rtl/rst_sys_stage.sv
`timescale 1ns/10ps
module rst_sys_stage #(
  parameter int unsigned STAGE_LEN   = rst_seq_pkg::DEF_STAGE,
  parameter int unsigned SYNC_STAGES = rst_seq_pkg::DEF_SYNC
) (
  input  logic sys_clk,
  input  logic up_rst_n,
  output logic stage_rst_n
);
  import rst_seq_pkg::*;

  localparam int unsigned W = cnt_w(STAGE_LEN);
  localparam logic [W-1:0] TGT = W'(STAGE_LEN);

  logic         armed;
  logic [W-1:0] cnt_q;
  logic         done;
  logic         rel_q;

  generate
    if (SYNC_STAGES > 0) begin : g_sync
      // upstream comes from another clock domain
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge sys_clk or negedge up_rst_n) begin
        if (!up_rst_n) sync_q <= '0;
        else           sync_q <= (sync_q << 1) | SYNC_STAGES'(1);
      end
      assign armed = sync_q[SYNC_STAGES-1];
    end else begin : g_direct
      // upstream already released on a sys_clk falling edge
      assign armed = up_rst_n;
    end
  endgenerate

  assign done = (cnt_q == TGT);

  always_ff @(posedge sys_clk or negedge up_rst_n) begin
    if (!up_rst_n)           cnt_q <= '0;
    else if (armed && !done) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(negedge sys_clk or negedge up_rst_n) begin
    if (!up_rst_n) rel_q <= 1'b0;
    else           rel_q <= done;
  end

  assign stage_rst_n = rel_q;

endmodule

// File: rtl/rst_phase_seq.sv
`timescale 1ns/10ps
module rst_phase_seq #(
  parameter int unsigned NUM_SRC       = rst_seq_pkg::DEF_NUM_SRC,
  parameter int unsigned LONG_STRETCH  = rst_seq_pkg::DEF_LONG,
  parameter int unsigned SHORT_STRETCH = rst_seq_pkg::DEF_SHORT,
  parameter int unsigned STAGE_LEN     = rst_seq_pkg::DEF_STAGE,
  parameter int unsigned SYNC_STAGES   = rst_seq_pkg::DEF_SYNC
) (
  input  logic               osc_clk,
  input  logic               sys_clk,
  input  logic [NUM_SRC-1:0] rst_src_n,
  input  logic               por_flag,
  output logic               clkgen_rst_n,
  output logic               perip_rst_n,
  output logic               core_rst_n
);

  logic comb_n;
  logic por_cause;

  rst_src_combine #(.NUM_SRC(NUM_SRC)) u_combine (
    .osc_clk   (osc_clk),
    .src_n     (rst_src_n),
    .por_flag  (por_flag),
    .comb_n    (comb_n),
    .por_cause (por_cause)
  );

  rst_osc_stretch #(
    .LONG_STRETCH  (LONG_STRETCH),
    .SHORT_STRETCH (SHORT_STRETCH),
    .SYNC_STAGES   (SYNC_STAGES)
  ) u_stretch (
    .osc_clk      (osc_clk),
    .comb_n       (comb_n),
    .por_cause    (por_cause),
    .clkgen_rst_n (clkgen_rst_n)
  );

  // peripheral stage crosses from the oscillator domain
  rst_sys_stage #(.STAGE_LEN(STAGE_LEN), .SYNC_STAGES(SYNC_STAGES)) u_perip (
    .sys_clk     (sys_clk),
    .up_rst_n    (clkgen_rst_n),
    .stage_rst_n (perip_rst_n)
  );

  // core stage follows in the same domain
  rst_sys_stage #(.STAGE_LEN(STAGE_LEN), .SYNC_STAGES(0)) u_core (
    .sys_clk     (sys_clk),
    .up_rst_n    (perip_rst_n),
    .stage_rst_n (core_rst_n)
  );

endmodule

// File: rtl/rst_phase_seq_chk.sv
`timescale 1ns/10ps
module rst_phase_seq_chk #(
  parameter int unsigned NUM_SRC     = rst_seq_pkg::DEF_NUM_SRC,
  parameter int unsigned STAGE_LEN   = rst_seq_pkg::DEF_STAGE,
  parameter int unsigned SYNC_STAGES = rst_seq_pkg::DEF_SYNC
) (
  input logic               osc_clk,
  input logic               sys_clk,
  input logic [NUM_SRC-1:0] rst_src_n,
  input logic               clkgen_rst_n,
  input logic               perip_rst_n,
  input logic               core_rst_n
);
  import rst_seq_pkg::*;

  localparam int unsigned CMAX = STAGE_LEN + SYNC_STAGES + 1;
  localparam int unsigned CW   = cnt_w(CMAX);

  logic          comb_n;
  logic [CW-1:0] cg_hi_cnt;
  logic [CW-1:0] pr_hi_cnt;

  assign comb_n = &rst_src_n;

  // sys_clk rising edges seen with each upstream reset released
  always_ff @(posedge sys_clk or negedge clkgen_rst_n) begin
    if (!clkgen_rst_n)            cg_hi_cnt <= '0;
    else if (cg_hi_cnt != CW'(CMAX)) cg_hi_cnt <= cg_hi_cnt + 1'b1;
  end

  always_ff @(posedge sys_clk or negedge perip_rst_n) begin
    if (!perip_rst_n)             pr_hi_cnt <= '0;
    else if (pr_hi_cnt != CW'(CMAX)) pr_hi_cnt <= pr_hi_cnt + 1'b1;
  end

  always @(negedge sys_clk) begin
    if (!comb_n) begin
      assert_all_held_R1: assert (!clkgen_rst_n && !perip_rst_n && !core_rst_n);
    end
  end

  always @(posedge clkgen_rst_n) begin
    assert_clkgen_on_fall_R5: assert (osc_clk == 1'b0);
  end

  always @(posedge perip_rst_n) begin
    assert_perip_delay_R6: assert (cg_hi_cnt == CW'(STAGE_LEN + SYNC_STAGES));
  end

  always @(posedge core_rst_n) begin
    assert_core_delay_R7: assert (pr_hi_cnt == CW'(STAGE_LEN));
  end

  assert_core_after_perip_R8: assert property (
    @(posedge sys_clk) disable iff (!comb_n) core_rst_n |-> perip_rst_n);

  assert_perip_after_clkgen_R8: assert property (
    @(posedge sys_clk) disable iff (!comb_n) perip_rst_n |-> clkgen_rst_n);

endmodule

bind rst_phase_seq rst_phase_seq_chk #(
  .NUM_SRC     (NUM_SRC),
  .STAGE_LEN   (STAGE_LEN),
  .SYNC_STAGES (SYNC_STAGES)
) u_chk (
  .osc_clk      (osc_clk),
  .sys_clk      (sys_clk),
  .rst_src_n    (rst_src_n),
  .clkgen_rst_n (clkgen_rst_n),
  .perip_rst_n  (perip_rst_n),
  .core_rst_n   (core_rst_n)
);

// File: tb/tb_rst_phase_seq.sv
`timescale 1ns/10ps
module tb_rst_phase_seq;
  import rst_seq_pkg::*;

  localparam int NSRC = DEF_NUM_SRC;

  typedef struct {
    int stage;   // 0 clkgen, 1 perip, 2 core
    int cyc;
  } exp_t;

  logic            osc_clk = 1'b0;
  logic            sys_clk = 1'b0;
  logic [NSRC-1:0] src_n   = '0;
  logic            por_flag = 1'b1;
  logic            clkgen_rst_n, perip_rst_n, core_rst_n;

  int   n_chk  = 0;
  int   n_fail = 0;
  bit   ended  = 1'b0;
  exp_t q[$];

  int osc_cnt = 0;
  int sys_a   = 0;
  int sys_b   = 0;

  rst_phase_seq dut (
    .osc_clk      (osc_clk),
    .sys_clk      (sys_clk),
    .rst_src_n    (src_n),
    .por_flag     (por_flag),
    .clkgen_rst_n (clkgen_rst_n),
    .perip_rst_n  (perip_rst_n),
    .core_rst_n   (core_rst_n)
  );

  // sys_clk 200 MHz, edges on quarter-ns offsets so they never meet osc edges
  initial begin
    #1.25;
    forever #2.5 sys_clk = ~sys_clk;
  end
  initial forever #7 osc_clk = ~osc_clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  // reference edge counters, derived from ports only
  always @(posedge osc_clk) osc_cnt <= (&src_n) ? osc_cnt + 1 : 0;
  always @(posedge sys_clk) sys_a   <= clkgen_rst_n ? sys_a + 1 : 0;
  always @(posedge sys_clk) sys_b   <= perip_rst_n  ? sys_b + 1 : 0;

  // monitors: pop expected releases in order
  always @(posedge clkgen_rst_n) begin : mon_cg
    exp_t e;
    if (q.size() == 0) chk(1'b0, "R9 unexpected clkgen release", 1, 0);
    else begin
      e = q.pop_front();
      chk(e.stage == 0, "R8 clkgen released out of order", e.stage, 0);
      chk(osc_cnt == e.cyc, "R3 R4 stretch length", osc_cnt, e.cyc);
      chk(osc_clk == 1'b0, "R5 clkgen not on osc falling edge", osc_clk, 0);
      chk(!perip_rst_n && !core_rst_n, "R8 later stage early", perip_rst_n, 0);
    end
  end

  always @(posedge perip_rst_n) begin : mon_pr
    exp_t e;
    if (q.size() == 0) chk(1'b0, "R9 unexpected perip release", 1, 0);
    else begin
      e = q.pop_front();
      chk(e.stage == 1, "R8 perip released out of order", e.stage, 1);
      chk(sys_a == e.cyc, "R6 perip delay", sys_a, e.cyc);
      chk(sys_clk == 1'b0, "R6 perip not on sys falling edge", sys_clk, 0);
      chk(!core_rst_n, "R8 core before perip", core_rst_n, 0);
    end
  end

  always @(posedge core_rst_n) begin : mon_co
    exp_t e;
    if (q.size() == 0) chk(1'b0, "R9 unexpected core release", 1, 0);
    else begin
      e = q.pop_front();
      chk(e.stage == 2, "R8 core released out of order", e.stage, 2);
      chk(sys_b == e.cyc, "R7 core delay", sys_b, e.cyc);
      chk(sys_clk == 1'b0, "R7 core not on sys falling edge", sys_clk, 0);
    end
  end

  task automatic push_full(input bit por);
    q.push_back('{0, por ? int'(DEF_LONG) : int'(DEF_SHORT)});
    q.push_back('{1, int'(DEF_STAGE + DEF_SYNC)});
    q.push_back('{2, int'(DEF_STAGE)});
  endtask

  // hold a reset pattern, then release and wait for the core
  task automatic run_seq(input logic [NSRC-1:0] hold_n, input bit por);
    src_n    = hold_n;
    por_flag = por;
    repeat (3) @(posedge osc_clk);
    #3;
    chk({clkgen_rst_n, perip_rst_n, core_rst_n} == 3'b000,
        "R1 outputs held during reset", {clkgen_rst_n, perip_rst_n, core_rst_n}, 0);
    push_full(por);
    src_n = '1;
    wait (core_rst_n);
    repeat (4) @(posedge sys_clk);
  endtask

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    // power-on from every source at once
    run_seq('0, 1'b1);

    // each source alone, alternating cause
    for (int i = 0; i < NSRC; i++) begin
      @(posedge osc_clk); #3;
      src_n = ~(NSRC'(1) << i);
      #0.2;
      chk({clkgen_rst_n, perip_rst_n, core_rst_n} == 3'b000,
          "R2 R1 async assertion from single source",
          {clkgen_rst_n, perip_rst_n, core_rst_n}, 0);
      run_seq(~(NSRC'(1) << i), i[0] == 1'b0);
    end

    // two sources together, non power-on
    run_seq(4'b0110, 1'b0);

    // abort between clkgen and perip release
    src_n = 4'b1011; por_flag = 1'b1;
    repeat (3) @(posedge osc_clk); #3;
    q.push_back('{0, int'(DEF_LONG)});
    src_n = '1;
    wait (clkgen_rst_n);
    repeat (5) @(posedge sys_clk); #1;
    chk(!perip_rst_n && !core_rst_n, "R6 perip still held mid-gap", perip_rst_n, 0);
    src_n[2] = 1'b0;
    #0.2;
    chk({clkgen_rst_n, perip_rst_n, core_rst_n} == 3'b000,
        "R9 abort drops all outputs", {clkgen_rst_n, perip_rst_n, core_rst_n}, 0);
    run_seq(4'b1011, 1'b0);

    #20;
    chk(q.size() == 0, "R9 all expected releases seen", q.size(), 0);
    summary();
  end

endmodule